// File: doc/BRIEF.md
# Block and Byte Transfer Counter Engine

This engine moves payload between a 16-bit word FIFO and a card data path that carries one byte at a time. Two live counters drive it. One holds the bytes still due in the current block. The other holds the blocks still due in the whole transfer. A pulse on `xfer_start` begins a transfer, and `xfer_dir` picks its direction.

In the read direction, the engine packs card bytes into words and pushes each word into the FIFO. It stops fetching while the FIFO holds more words than the almost-full threshold. In the write direction, it takes the head word of the FIFO, sends its bytes to the card, and then pops the word. It waits while the FIFO is empty. When the last byte of the last block has moved, the engine clears `xfer_active`, raises `xfer_done` for one cycle, and leaves both counters reloaded for the next data command.

Both card byte streams use valid/ready handshakes:

- A byte moves only in a cycle where valid and ready are both high.
- At most one byte moves per clock.
- The card side may hold valid (read) or ready (write) low for any number of cycles, and the engine simply waits.
- Back-pressure toward the card comes only from FIFO occupancy.
- The FIFO is assumed to accept every push, and `fifo_level` is assumed to change only on the clock edge after a push or pop.

Top module: `blk_xfer_engine`

## Requirements
- R1: A write of `cfg_len_val` with `cfg_len_we` sets the block length to that value plus one, and `bytes_left` shows the new length on the next cycle.
- R2: A write of `cfg_cnt_val` with `cfg_cnt_we` sets the block count to that value plus one. `blocks_left` shows it on the next cycle, and `bytes_left` reloads from the block length (the newly written one if both writes share a cycle). A configuration write in a cycle takes the place of any counting step in that cycle.
- R3: Reading (`xfer_dir`=1): the first byte of a word lands in bits 7:0 and the next byte in bits 15:8. The second byte is fetched only if the block still has bytes left after the first. When a block ends on an odd byte, the word is pushed with bits 15:8 zero.
- R4: Writing (`xfer_dir`=0): bits 7:0 of the head word go out first, then bits 15:8 only if the block still has bytes left. `pop_word` pulses in the cycle the word's last byte is accepted.
- R5: Reading: a new word is not started (`card_rx_ready` low) while `fifo_level` is greater than `af_level`, so every push finds `fifo_level` no greater than `af_level`.
- R6: Writing: `card_tx_valid` stays low while `fifo_level` is zero.
- R7: Each byte moved lowers `bytes_left` by one. On the block's last byte, `bytes_left` reloads to the block length and `blocks_left` drops by one. Both counters are live outputs.
- R8: On the last byte of the last block, `blocks_left` reloads to the block count, `xfer_active` falls, and `xfer_done` is high for exactly the next cycle.
- R9: While `xfer_active` is low, `card_rx_ready`, `card_tx_valid`, `push_valid` and `pop_word` stay low, and bytes offered by the card leave both counters unchanged.
- R10: A byte moves only when valid and ready are both high, at most one per clock. A new `xfer_start` resumes from the reloaded counters, beginning with the low half of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_we | input | 1 | Load block length |
| cfg_len_val | input | LEN_W | Block length minus one |
| cfg_cnt_we | input | 1 | Load block count |
| cfg_cnt_val | input | LEN_W | Block count minus one |
| xfer_start | input | 1 | Start pulse of a data transfer |
| xfer_dir | input | 1 | 1 = card to FIFO, 0 = FIFO to card |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle end-of-transfer flag |
| bytes_left | output | LEN_W+1 | Live byte counter of the current block |
| blocks_left | output | LEN_W+1 | Live block counter |
| fifo_level | input | LVL_W | Words held in the FIFO |
| af_level | input | THR_W | Almost-full threshold |
| push_valid | output | 1 | Push a word into the FIFO |
| push_data | output | 16 | Word to push |
| pop_data | input | 16 | FIFO head word |
| pop_word | output | 1 | Pop the FIFO head |
| card_rx_valid | input | 1 | Card offers a byte |
| card_rx_ready | output | 1 | Engine takes the byte |
| card_rx_data | input | 8 | Byte from the card |
| card_tx_valid | output | 1 | Engine offers a byte |
| card_tx_ready | input | 1 | Card takes the byte |
| card_tx_data | output | 8 | Byte to the card |

## Verification
A wrong byte counter shows up on `bytes_left` one cycle after the faulty step. Within the same block it also moves the split between half-filled and full words, so a read pushes a word with a stray high byte, or a write sends one byte too many or too few before `pop_word`. A wrong block counter shows up on `blocks_left` at the next block boundary. It then makes `xfer_done` arrive one block early or late, with the counters reloaded to the wrong values. A wrong half-word phase shows up at once, as swapped bytes in `push_data` or `card_tx_data` on the next handshake.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } xfer_dir_e;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/xfer_count.sv
module xfer_count #(
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_val,
  input  logic             cnt_we,
  input  logic [LEN_W-1:0] cnt_val,
  input  logic             step,
  output logic [LEN_W:0]   bytes_left,
  output logic [LEN_W:0]   blocks_left,
  output logic             last_byte,
  output logic             xfer_end
);
  localparam int unsigned CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] len_q, nblk_q, bytes_q, blocks_q;
  logic [CNT_W-1:0] len_new, nblk_new;

  assign len_new  = {1'b0, len_val} + CNT_W'(1);
  assign nblk_new = {1'b0, cnt_val} + CNT_W'(1);

  assign last_byte   = (bytes_q == CNT_W'(1));
  assign xfer_end    = step && last_byte && (blocks_q == CNT_W'(1));
  assign bytes_left  = bytes_q;
  assign blocks_left = blocks_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= '0;
      nblk_q   <= '0;
      bytes_q  <= '0;
      blocks_q <= '0;
    end else if (len_we || cnt_we) begin
      if (len_we) begin
        len_q   <= len_new;
        bytes_q <= len_new;
      end
      if (cnt_we) begin
        nblk_q   <= nblk_new;
        blocks_q <= nblk_new;
        bytes_q  <= len_we ? len_new : len_q;
      end
    end else if (step) begin
      if (last_byte) begin
        bytes_q <= len_q;
        if (blocks_q == CNT_W'(1)) blocks_q <= nblk_q;
        else                       blocks_q <= blocks_q - CNT_W'(1);
      end else begin
        bytes_q <= bytes_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/xfer_rd_pack.sv
module xfer_rd_pack
  import blk_xfer_pkg::*;
#(
  parameter int unsigned LVL_W = 6,
  parameter int unsigned THR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [THR_W-1:0]  af_level,
  input  logic              last_byte,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              take,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_data
);
  half_e             half_q;
  logic [BYTE_W-1:0] lo_q;
  logic [LVL_W-1:0]  af_ext;
  logic              room;

  assign af_ext     = LVL_W'(af_level);
  assign room       = (fifo_level <= af_ext);
  assign rx_ready   = en && ((half_q == HALF_HI) || room);
  assign take       = rx_valid && rx_ready;
  assign push_valid = take && ((half_q == HALF_HI) || last_byte);
  assign push_data  = (half_q == HALF_HI) ? {rx_data, lo_q} : {{BYTE_W{1'b0}}, rx_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= HALF_LO;
      lo_q   <= '0;
    end else if (restart) begin
      half_q <= HALF_LO;
    end else if (take) begin
      if (half_q == HALF_HI) begin
        half_q <= HALF_LO;
      end else begin
        lo_q   <= rx_data;
        half_q <= last_byte ? HALF_LO : HALF_HI;
      end
    end
  end
endmodule

// File: rtl/xfer_wr_split.sv
module xfer_wr_split
  import blk_xfer_pkg::*;
#(
  parameter int unsigned LVL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              restart,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [WORD_W-1:0] pop_data,
  input  logic              last_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              send,
  output logic              pop
);
  half_e half_q;

  assign tx_valid = en && (fifo_level != '0);
  assign tx_data  = (half_q == HALF_HI) ? pop_data[WORD_W-1:BYTE_W] : pop_data[BYTE_W-1:0];
  assign send     = tx_valid && tx_ready;
  assign pop      = send && ((half_q == HALF_HI) || last_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= HALF_LO;
    end else if (restart) begin
      half_q <= HALF_LO;
    end else if (send) begin
      if (half_q == HALF_HI) half_q <= HALF_LO;
      else                   half_q <= last_byte ? HALF_LO : HALF_HI;
    end
  end
endmodule

// File: rtl/blk_xfer_engine.sv
module blk_xfer_engine
  import blk_xfer_pkg::*;
#(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned LVL_W = 6,
  parameter int unsigned THR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len_val,
  input  logic              cfg_cnt_we,
  input  logic [LEN_W-1:0]  cfg_cnt_val,
  input  logic              xfer_start,
  input  logic              xfer_dir,
  output logic              xfer_active,
  output logic              xfer_done,
  output logic [LEN_W:0]    bytes_left,
  output logic [LEN_W:0]    blocks_left,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [THR_W-1:0]  af_level,
  output logic              push_valid,
  output logic [WORD_W-1:0] push_data,
  input  logic [WORD_W-1:0] pop_data,
  output logic              pop_word,
  input  logic              card_rx_valid,
  output logic              card_rx_ready,
  input  logic [BYTE_W-1:0] card_rx_data,
  output logic              card_tx_valid,
  input  logic              card_tx_ready,
  output logic [BYTE_W-1:0] card_tx_data
);
  logic      active_q, done_q;
  xfer_dir_e dir_q;
  logic      en_rd, en_wr;
  logic      rx_take, tx_send, step;
  logic      last_byte, xfer_end;

  assign en_rd = active_q && (dir_q == DIR_RD);
  assign en_wr = active_q && (dir_q == DIR_WR);
  assign step  = rx_take || tx_send;

  xfer_count #(.LEN_W(LEN_W)) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_we      (cfg_len_we),
    .len_val     (cfg_len_val),
    .cnt_we      (cfg_cnt_we),
    .cnt_val     (cfg_cnt_val),
    .step        (step),
    .bytes_left  (bytes_left),
    .blocks_left (blocks_left),
    .last_byte   (last_byte),
    .xfer_end    (xfer_end)
  );

  xfer_rd_pack #(.LVL_W(LVL_W), .THR_W(THR_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_rd),
    .restart    (xfer_start),
    .fifo_level (fifo_level),
    .af_level   (af_level),
    .last_byte  (last_byte),
    .rx_valid   (card_rx_valid),
    .rx_data    (card_rx_data),
    .rx_ready   (card_rx_ready),
    .take       (rx_take),
    .push_valid (push_valid),
    .push_data  (push_data)
  );

  xfer_wr_split #(.LVL_W(LVL_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_wr),
    .restart    (xfer_start),
    .fifo_level (fifo_level),
    .pop_data   (pop_data),
    .last_byte  (last_byte),
    .tx_ready   (card_tx_ready),
    .tx_valid   (card_tx_valid),
    .tx_data    (card_tx_data),
    .send       (tx_send),
    .pop        (pop_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= DIR_WR;
      done_q   <= 1'b0;
    end else begin
      done_q <= xfer_end;
      if (xfer_start) begin
        active_q <= 1'b1;
        dir_q    <= xfer_dir_e'(xfer_dir);
      end else if (xfer_end) begin
        active_q <= 1'b0;
      end
    end
  end

  assign xfer_active = active_q;
  assign xfer_done   = done_q;
endmodule

// File: rtl/blk_xfer_engine_chk.sv
module blk_xfer_engine_chk #(
  parameter int unsigned LEN_W = 11,
  parameter int unsigned LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_len_we,
  input logic [LEN_W-1:0] cfg_len_val,
  input logic             cfg_cnt_we,
  input logic [LEN_W-1:0] cfg_cnt_val,
  input logic             xfer_active,
  input logic             xfer_done,
  input logic [LEN_W:0]   bytes_left,
  input logic [LEN_W:0]   blocks_left,
  input logic [LVL_W-1:0] fifo_level,
  input logic             push_valid,
  input logic             pop_word,
  input logic             card_rx_valid,
  input logic             card_rx_ready,
  input logic             card_tx_valid,
  input logic             card_tx_ready
);
  p_len_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_len_we |=> bytes_left == ({1'b0, $past(cfg_len_val)} + (LEN_W+1)'(1)));

  p_cnt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cnt_we |=> blocks_left == ({1'b0, $past(cfg_cnt_val)} + (LEN_W+1)'(1)));

  p_push_on_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (card_rx_valid && card_rx_ready));

  p_pop_on_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_word |-> (card_tx_valid && card_tx_ready));

  p_empty_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |-> !card_tx_valid);

  p_done_after_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> $past(xfer_active));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> (!card_rx_ready && !card_tx_valid && !push_valid && !pop_word));

  p_one_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({card_rx_valid && card_rx_ready, card_tx_valid && card_tx_ready}) <= 1);
endmodule

bind blk_xfer_engine blk_xfer_engine_chk #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/blk_xfer_engine_bench.sv
`timescale 1ns/100ps
module blk_xfer_engine_bench;
  localparam int LEN_W = 11;
  localparam int LVL_W = 6;
  localparam int THR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cfg_len_we = 0, cfg_cnt_we = 0;
  logic [LEN_W-1:0] cfg_len_val = '0, cfg_cnt_val = '0;
  logic             xfer_start = 0, xfer_dir = 0;
  logic             xfer_active, xfer_done;
  logic [LEN_W:0]   bytes_left, blocks_left;
  logic [LVL_W-1:0] fifo_level;
  logic [THR_W-1:0] af_level = 5'd31;
  logic             push_valid, pop_word;
  logic [15:0]      push_data, pop_data;
  logic             card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;
  logic [7:0]       card_rx_data, card_tx_data;

  blk_xfer_engine u_blk_xfer_engine (.*);

  int n_checks = 0, n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gbyte(input int i);
    return 8'(i * 5 + 3);
  endfunction
  function automatic logic [15:0] wword(input int k);
    return {8'(k * 7 + 1), 8'(k * 13 + 2)};
  endfunction

  // bench model state
  logic        run = 0, rd = 0, idle_poke = 0;
  int          L = 1, N = 1, mb = 0, mn = 0, lvl = 0, idle_level = 0;
  int          cyc = 0, rd_idx = 0, npush = 0, nbyte = 0, popped = 0, loaded = 0;
  int          nwords = 0, nbytes = 0, ndone = 0;
  int          wbad = 0, cnt_bad = 0, r5bad = 0, r6bad = 0;
  logic [7:0]  lfsr = 8'h5b;
  logic [15:0] exp_w [0:63];
  logic [7:0]  exp_b [0:63];

  always @(negedge clk) begin
    if (run) begin
      if (bytes_left !== (LEN_W+1)'(mb) || blocks_left !== (LEN_W+1)'(mn)) cnt_bad++;
      if (rd) begin
        if (lvl > 0 && cyc[0]) lvl--;
        card_rx_valid = lfsr[0] | lfsr[1];
        card_rx_data  = gbyte(rd_idx);
        card_tx_ready = 1'b0;
        pop_data      = 16'h0;
      end else begin
        if ((cyc % 3) == 0 && loaded < nwords) begin loaded++; lvl++; end
        pop_data      = wword(popped);
        card_tx_ready = lfsr[0] | lfsr[2];
        card_rx_valid = 1'b0;
        card_rx_data  = 8'h00;
      end
      fifo_level = LVL_W'(lvl);
      #1;
      if (card_rx_valid && card_rx_ready) begin
        rd_idx++;
        if (mb == 1) begin mb = L; mn = (mn == 1) ? N : mn - 1; end else mb--;
      end
      if (push_valid) begin
        if (lvl > int'(af_level)) r5bad++;
        if (npush >= 64 || push_data !== exp_w[npush]) wbad++;
        npush++; lvl++;
      end
      if (card_tx_valid && lvl == 0) r6bad++;
      if (card_tx_valid && card_tx_ready) begin
        if (nbyte >= 64 || card_tx_data !== exp_b[nbyte]) wbad++;
        nbyte++;
        if (mb == 1) begin mb = L; mn = (mn == 1) ? N : mn - 1; end else mb--;
      end
      if (pop_word) begin popped++; lvl--; end
      if (xfer_done) ndone++;
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end else begin
      card_rx_valid = idle_poke;
      card_rx_data  = 8'hA5;
      card_tx_ready = 1'b1;
      fifo_level    = LVL_W'(idle_level);
      pop_data      = 16'h1234;
    end
  end

  task automatic drive_slot();
    @(negedge clk);
    #0.5;
  endtask

  task automatic build_expect(input bit dir_rd);
    int r, bi, wi, k;
    bi = 0; wi = 0; k = 0;
    for (int b = 0; b < N; b++) begin
      r = L;
      while (r > 0) begin
        if (dir_rd) begin
          exp_w[wi][7:0] = gbyte(bi); bi++; r--;
          if (r > 0) begin exp_w[wi][15:8] = gbyte(bi); bi++; r--; end
          else exp_w[wi][15:8] = 8'h00;
        end else begin
          exp_b[bi] = wword(wi)[7:0]; bi++; r--;
          if (r > 0) begin exp_b[bi] = wword(wi)[15:8]; bi++; r--; end
        end
        wi++;
      end
    end
    nwords = wi; nbytes = bi;
  endtask

  task automatic run_xfer(input bit dir_rd, input int len, input int cnt, input int af, input bit prog);
    string tag;
    L = len; N = cnt;
    if (prog) begin
      drive_slot();
      cfg_len_we = 1; cfg_len_val = LEN_W'(len - 1);
      cfg_cnt_we = 1; cfg_cnt_val = LEN_W'(cnt - 1);
      drive_slot();
      cfg_len_we = 0; cfg_cnt_we = 0;
    end else begin
      drive_slot();
    end
    build_expect(dir_rd);
    af_level = THR_W'(af);
    mb = len; mn = cnt; lvl = 0; cyc = 0; rd_idx = 0; npush = 0; nbyte = 0;
    popped = 0; loaded = 0; ndone = 0; wbad = 0; cnt_bad = 0; r5bad = 0; r6bad = 0;
    rd = dir_rd;
    xfer_dir = dir_rd; xfer_start = 1; run = 1;
    drive_slot();
    xfer_start = 0;
    for (int c = 0; c < 3000 && ndone == 0; c++) @(negedge clk);
    repeat (3) @(negedge clk);
    #0.5;
    run = 0;
    tag = $sformatf("dir=%0d L=%0d N=%0d af=%0d", dir_rd, len, cnt, af);
    if (dir_rd) begin
      chk({"R3 words pushed ", tag}, npush, nwords);
      chk({"R3 word content mismatches ", tag}, wbad, 0);
      chk({"R5 push above threshold ", tag}, r5bad, 0);
    end else begin
      chk({"R4 bytes sent ", tag}, nbyte, nbytes);
      chk({"R4 words popped ", tag}, popped, nwords);
      chk({"R4 byte order mismatches ", tag}, wbad, 0);
      chk({"R6 send from empty fifo ", tag}, r6bad, 0);
    end
    chk({"R7 live counter mismatches ", tag}, cnt_bad, 0);
    chk({"R8 done pulses ", tag}, ndone, 1);
    chk({"R8 active cleared ", tag}, xfer_active, 0);
    chk({"R8 bytes_left reloaded ", tag}, bytes_left, len);
    chk({"R8 blocks_left reloaded ", tag}, blocks_left, cnt);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int bad_rx, bad_tx;
    repeat (3) @(negedge clk);
    #0.5;
    rst_n = 1;
    drive_slot();
    chk("reset bytes_left", bytes_left, 0);
    chk("reset blocks_left", blocks_left, 0);
    chk("reset xfer_active", xfer_active, 0);
    chk("reset xfer_done", xfer_done, 0);

    // R1 / R2 loading
    cfg_len_we = 1; cfg_len_val = 11'd4;
    drive_slot(); cfg_len_we = 0;
    chk("R1 length load", bytes_left, 5);
    cfg_cnt_we = 1; cfg_cnt_val = 11'd2;
    drive_slot(); cfg_cnt_we = 0;
    chk("R2 count load", blocks_left, 3);
    chk("R2 byte reload", bytes_left, 5);
    cfg_len_we = 1; cfg_len_val = 11'd6;
    drive_slot(); cfg_len_we = 0;
    chk("R1 length reload", bytes_left, 7);
    chk("R1 count untouched", blocks_left, 3);
    cfg_cnt_we = 1; cfg_cnt_val = 11'd0;
    drive_slot(); cfg_cnt_we = 0;
    chk("R2 single block", blocks_left, 1);
    cfg_len_we = 1; cfg_len_val = 11'd2047; cfg_cnt_we = 1; cfg_cnt_val = 11'd2047;
    drive_slot(); cfg_len_we = 0; cfg_cnt_we = 0;
    chk("R1 max length", bytes_left, 2048);
    chk("R2 max count", blocks_left, 2048);

    // R9: idle engine ignores offered bytes
    cfg_len_we = 1; cfg_len_val = 11'd2; cfg_cnt_we = 1; cfg_cnt_val = 11'd1;
    drive_slot(); cfg_len_we = 0; cfg_cnt_we = 0;
    idle_poke = 1; idle_level = 5; af_level = 5'd31;
    bad_rx = 0; bad_tx = 0;
    for (int i = 0; i < 6; i++) begin
      drive_slot();
      if (card_rx_ready) bad_rx++;
      if (card_tx_valid) bad_tx++;
    end
    idle_poke = 0; idle_level = 0;
    chk("R9 rx_ready while idle", bad_rx, 0);
    chk("R9 tx_valid while idle", bad_tx, 0);
    chk("R9 bytes_left unchanged", bytes_left, 3);
    chk("R9 blocks_left unchanged", blocks_left, 2);

    // Sweep over directions, lengths, counts and thresholds (R3-R8, R10)
    for (int d = 0; d < 2; d++)
      for (int ln = 1; ln <= 5; ln++)
        for (int nb = 1; nb <= 3; nb++)
          for (int a = 0; a < 2; a++)
            run_xfer(d[0], ln, nb, a * 3, 1'b1);

    // R10: restart without reprogramming uses reloaded counters
    run_xfer(1'b1, 3, 2, 1, 1'b1);
    run_xfer(1'b1, 3, 2, 1, 1'b0);
    run_xfer(1'b0, 3, 2, 1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule